// File: doc/BRIEF.md
# Dual-Mode Auto-Reload Timer

This peripheral keeps a 16-bit count as two byte halves together with a matching pair of reload bytes. Depending on a mode bit, the two halves work as one 16-bit up-counter or as two separate 8-bit up-counters. Each counter reloads itself from its reload value when it wraps past its maximum. Counting advances on a tick. The tick is chosen from three sources: every system clock cycle, one cycle in twelve, or one in every eight rising edges of an external clock. The external clock is first brought into the system clock domain through a synchronizer.

Software reaches the block through a byte-wide register port with one address bus shared by reads and writes. It sets the run enable, the mode, the tick source and the interrupt enables, and it reads and clears two sticky overflow flags. The block drives a level interrupt request. It also drives a one-cycle overflow pulse that a neighbouring block, such as a converter start trigger, can use.

Top module: `reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and `irq` and `ovf_pulse` are low.
- R2: Register addresses are 0 control, 1 reload low, 2 reload high, 3 count low and 4 count high. Any other address reads 0x00. `rd_data` holds the value the addressed register had before the clock edge that samples `addr`. A write with `wr_en` high takes effect on that same edge.
- R3: In 16-bit mode (control bit 1 = 0), a tick at count 0xFFFF loads the 16-bit reload value and sets the high flag (control bit 7). The overflow period is therefore 0x10000 minus the reload value, counted in ticks.
- R4: Control bits 3:2 select the tick source. Code 0 or 3 ticks on every cycle. Code 1 ticks once every 12 cycles. Code 2 ticks once every 8 rising edges of `ext_clk`, after those edges pass through a two-flop synchronizer.
- R5: In 16-bit mode the count does not change while the run bit (control bit 0) is 0.
- R6: In 16-bit mode, every low-byte rollover from 0xFF sets the low flag (control bit 6).
- R7: The flags are sticky. A control write with 0 in a flag bit clears that flag, and a write with 1 leaves it unchanged. A flag set by hardware wins over a clear in the same cycle.
- R8: `irq` is high when the interrupt enable (control bit 5) is 1 and either the high flag is set, or the low flag is set while the low interrupt enable (control bit 4) is 1.
- R9: In split mode (control bit 1 = 1), the low byte counts only while the run bit is 1. When it wraps from 0xFF it loads the low reload byte and sets the low flag.
- R10: In split mode, the high byte counts on every tick whatever the run bit is. When it wraps from 0xFF it loads the high reload byte, sets the high flag and raises `ovf_pulse`.
- R11: A write to a count byte takes effect on that edge and overrides any increment of that byte in the same cycle.
- R12: `ovf_pulse` is high for exactly one cycle per high overflow event: a 16-bit wrap, or a high-byte wrap in split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external clock for the divide-by-8 tick source |
| addr | input | 3 | Register address for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | HALF_W | Write data |
| rd_data | output | HALF_W | Registered read data |
| irq | output | 1 | Interrupt request level |
| ovf_pulse | output | 1 | One-cycle high-overflow pulse for another peripheral |

## Verification
The bound checker checks the following on every cycle:
- the flags stay sticky unless a clear is written;
- the overflow pulse never appears without the high flag;
- an interrupt request never appears without a flag;
- the count holds while run is low in 16-bit mode;
- the split low byte holds while run is low;
- a count-byte write lands on the same edge.

Only the bench's scenarios can show the overflow periods. It sweeps reload values in both modes and on all tick-source codes, including the synchronized external divider. The same holds for the decoding of the interrupt enables and for read-back through the register port.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_RLO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RHI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLO  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CHI  = 3'd4;

  localparam logic [1:0] SRC_SYS  = 2'd0;
  localparam logic [1:0] SRC_DIV  = 2'd1;
  localparam logic [1:0] SRC_EXT  = 2'd2;

  localparam int FLAG_LO_BIT = 6;
  localparam int FLAG_HI_BIT = 7;

  // software-owned part of the control register, bits 5:0
  typedef struct packed {
    logic       irq_en;
    logic       lo_irq_en;
    logic [1:0] src;
    logic       split;
    logic       run;
  } cfg_t;

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen
  import reload_timer_pkg::*;
#(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_clk,
  input  logic [1:0] src,
  output logic       tick
);

  logic                 div_pulse;
  logic                 ext_pulse;
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;

  // synchronizer chain plus one stage of history for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  generate
    if (SYS_DIV > 1) begin : g_sys_div
      localparam int DW = $clog2(SYS_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(SYS_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q     <= '0;
          div_pulse <= 1'b0;
        end else begin
          div_q     <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
          div_pulse <= (div_q == DIV_LAST);
        end
      end
    end else begin : g_sys_nodiv
      assign div_pulse = 1'b1;
    end

    if (EXT_DIV > 1) begin : g_ext_div
      localparam int EW = $clog2(EXT_DIV);
      localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);
      logic [EW-1:0] edge_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          edge_q    <= '0;
          ext_pulse <= 1'b0;
        end else begin
          if (ext_rise) edge_q <= (edge_q == EXT_LAST) ? '0 : edge_q + 1'b1;
          ext_pulse <= ext_rise && (edge_q == EXT_LAST);
        end
      end
    end else begin : g_ext_nodiv
      always_ff @(posedge clk) begin
        if (rst) ext_pulse <= 1'b0;
        else     ext_pulse <= ext_rise;
      end
    end
  endgenerate

  always_comb begin
    case (src)
      SRC_DIV: tick = div_pulse;
      SRC_EXT: tick = ext_pulse;
      default: tick = 1'b1;
    endcase
  end

endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              split,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic [HALF_W-1:0] rl_lo,
  input  logic [HALF_W-1:0] rl_hi,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              ev_lo,
  output logic              ev_hi
);

  logic              lo_max, hi_max;
  logic              lo_step, hi_step;
  logic [HALF_W-1:0] lo_nxt, hi_nxt;

  assign lo_max  = &cnt_lo;
  assign hi_max  = &cnt_hi;
  assign lo_step = tick & run;
  // split: high half is free-running on the tick; joined: it takes the carry
  assign hi_step = split ? tick : (lo_step & lo_max);
  assign ev_lo   = lo_step & lo_max;
  assign ev_hi   = hi_step & hi_max;

  always_comb begin
    lo_nxt = cnt_lo;
    if (wr_lo) begin
      lo_nxt = wdata;
    end else if (lo_step) begin
      if (!lo_max)                lo_nxt = cnt_lo + 1'b1;
      else if (split || hi_max)   lo_nxt = rl_lo;
      else                        lo_nxt = '0;
    end
  end

  always_comb begin
    hi_nxt = cnt_hi;
    if (wr_hi) begin
      hi_nxt = wdata;
    end else if (hi_step) begin
      hi_nxt = hi_max ? rl_hi : cnt_hi + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_nxt;
      cnt_hi <= hi_nxt;
    end
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] rd_data,
  output logic              irq,
  output logic              ovf_pulse
);

  localparam int CFG_W = $bits(cfg_t);

  cfg_t              cfg;
  logic              flag_hi, flag_lo;
  logic [HALF_W-1:0] rl_lo, rl_hi;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              tick, ev_lo, ev_hi;
  logic              wr_ctrl, wr_clo, wr_chi;
  logic [7:0]        ctrl_word;
  logic [HALF_W-1:0] rd_mux;

  assign wr_ctrl = wr_en && (addr == ADR_CTRL);
  assign wr_clo  = wr_en && (addr == ADR_CLO);
  assign wr_chi  = wr_en && (addr == ADR_CHI);

  rt_tick_gen #(
    .SYS_DIV    (SYS_DIV),
    .EXT_DIV    (EXT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .ext_clk(ext_clk),
    .src    (cfg.src),
    .tick   (tick)
  );

  rt_counter #(
    .HALF_W(HALF_W)
  ) u_count (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .run   (cfg.run),
    .split (cfg.split),
    .wr_lo (wr_clo),
    .wr_hi (wr_chi),
    .wdata (wr_data),
    .rl_lo (rl_lo),
    .rl_hi (rl_hi),
    .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi),
    .ev_lo (ev_lo),
    .ev_hi (ev_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      flag_hi   <= 1'b0;
      flag_lo   <= 1'b0;
      rl_lo     <= '0;
      rl_hi     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      if (wr_ctrl) cfg <= cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_en && addr == ADR_RLO) rl_lo <= wr_data;
      if (wr_en && addr == ADR_RHI) rl_hi <= wr_data;
      // hardware set beats a software clear; writing 1 keeps the flag
      flag_hi   <= ev_hi | (flag_hi & ~(wr_ctrl & ~wr_data[FLAG_HI_BIT]));
      flag_lo   <= ev_lo | (flag_lo & ~(wr_ctrl & ~wr_data[FLAG_LO_BIT]));
      ovf_pulse <= ev_hi;
    end
  end

  assign ctrl_word = {flag_hi, flag_lo, cfg};

  always_comb begin
    case (addr)
      ADR_CTRL: rd_mux = HALF_W'(ctrl_word);
      ADR_RLO:  rd_mux = rl_lo;
      ADR_RHI:  rd_mux = rl_hi;
      ADR_CLO:  rd_mux = cnt_lo;
      ADR_CHI:  rd_mux = cnt_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign irq = cfg.irq_en & (flag_hi | (cfg.lo_irq_en & flag_lo));

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import reload_timer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        addr,
  input logic              wr_en,
  input logic [HALF_W-1:0] wr_data,
  input logic              irq,
  input logic              ovf_pulse,
  input logic              flag_hi,
  input logic              flag_lo,
  input logic              run,
  input logic              split,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi
);

  p_pulse_flag_r12: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> flag_hi);

  p_hi_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_hi) && !$past(rst) &&
     !$past(wr_en && addr == ADR_CTRL && !wr_data[FLAG_HI_BIT])) |-> flag_hi);

  p_lo_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_lo) && !$past(rst) &&
     !$past(wr_en && addr == ADR_CTRL && !wr_data[FLAG_LO_BIT])) |-> flag_lo);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_hi || flag_lo));

  p_hold_when_stopped_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run) && !$past(split) &&
     !$past(wr_en && (addr == ADR_CLO || addr == ADR_CHI)))
      |-> (cnt_lo == $past(cnt_lo) && cnt_hi == $past(cnt_hi)));

  p_split_lo_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(split) && !$past(run) &&
     !$past(wr_en && addr == ADR_CLO)) |-> (cnt_lo == $past(cnt_lo)));

  p_wr_lo_lands_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && addr == ADR_CLO)) |-> (cnt_lo == $past(wr_data)));

  p_wr_hi_lands_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && addr == ADR_CHI)) |-> (cnt_hi == $past(wr_data)));

endmodule

bind reload_timer reload_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .irq      (irq),
  .ovf_pulse(ovf_pulse),
  .flag_hi  (flag_hi),
  .flag_lo  (flag_lo),
  .run      (cfg.run),
  .split    (cfg.split),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  logic       ovf_pulse;

  int checks = 0;
  int fails  = 0;
  int ext_div_q = 0;

  reload_timer u_reload_timer (
    .clk      (clk),
    .rst      (rst),
    .ext_clk  (ext_clk),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq),
    .ovf_pulse(ovf_pulse)
  );

  always #10 clk = ~clk;

  // external clock: toggles every 2 cycles, one rising edge per 4 cycles
  always @(negedge clk) begin
    ext_div_q <= (ext_div_q == 1) ? 0 : ext_div_q + 1;
    if (ext_div_q == 1) ext_clk <= ~ext_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tasks start and end at a negative edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (ovf_pulse) c++;
    end
  endtask

  task automatic start(input logic [7:0] ctrl, input logic [15:0] rl);
    wr(3'd0, 8'h00);
    wr(3'd1, rl[7:0]);
    wr(3'd2, rl[15:8]);
    wr(3'd3, rl[7:0]);
    wr(3'd4, rl[15:8]);
    wr(3'd0, ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int c, p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 ovf_pulse", ovf_pulse, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end

    // R2: readback and unmapped address
    wr(3'd1, 8'h5A);
    wr(3'd2, 8'hA5);
    rd(3'd1, v); check("R2 reload lo", v, 8'h5A);
    rd(3'd2, v); check("R2 reload hi", v, 8'hA5);
    wr(3'd7, 8'hFF);
    rd(3'd7, v); check("R2 unmapped", v, 0);

    // R3/R12: 16-bit period sweep on every-cycle ticks
    for (int lo = 8'hF0; lo <= 8'hFF; lo++) begin
      p = 256 - lo;
      start(8'h01, {8'hFF, 8'(lo)});
      repeat (p + 4) @(negedge clk);
      count_pulses(3 * p, c);
      check("R3 R12 period", c, 3);
    end
    start(8'h01, 16'hFF00);
    repeat (260) @(negedge clk);
    count_pulses(512, c);
    check("R3 reload FF00", c, 2);
    rd(3'd0, v);
    check("R3 R6 flags after wrap", v, 8'hC1);

    // R7: write 1 keeps, write 0 clears
    wr(3'd0, 8'hC0);
    rd(3'd0, v); check("R7 write ones keep", v, 8'hC0);
    wr(3'd0, 8'h40);
    rd(3'd0, v); check("R7 clear hi only", v, 8'h40);
    wr(3'd0, 8'h00);
    rd(3'd0, v); check("R7 clear lo", v, 8'h00);

    // R4: tick sources
    start(8'h05, 16'hFFFC);
    repeat (60) @(negedge clk);
    count_pulses(144, c);
    check("R4 div12", c, 3);
    start(8'h09, 16'hFFFE);
    repeat (140) @(negedge clk);
    count_pulses(192, c);
    check("R4 ext div8", c, 3);
    start(8'h0D, 16'hFFF0);
    repeat (20) @(negedge clk);
    count_pulses(80, c);
    check("R4 code3 sysclk", c, 5);

    // R5: stopped in 16-bit mode
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h34);
    wr(3'd4, 8'h12);
    count_pulses(20, c);
    check("R5 no pulse when stopped", c, 0);
    rd(3'd3, v); check("R5 lo held", v, 8'h34);
    rd(3'd4, v); check("R5 hi held", v, 8'h12);

    // R6: low rollover without full wrap
    wr(3'd3, 8'hF8);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'hC0);
    rd(3'd0, v); check("R6 lo flag only", v, 8'h40);
    rd(3'd4, v); check("R6 carry into hi", v, 8'h01);

    // R8: interrupt decoding
    wr(3'd0, 8'hE0);
    check("R8 lo flag, lo irq off", irq, 0);
    wr(3'd0, 8'hF0);
    check("R8 lo flag, lo irq on", irq, 1);
    wr(3'd0, 8'hB0);
    check("R8 lo cleared", irq, 0);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'hFF);
    wr(3'd0, 8'h21);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'hA0);
    check("R8 hi flag irq", irq, 1);
    rd(3'd0, v); check("R8 ctrl", v, 8'hA0);
    wr(3'd0, 8'h80);
    check("R8 irq disabled", irq, 0);

    // R9: split low byte
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFC);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFC);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h03);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'hC2);
    rd(3'd0, v); check("R9 split lo flag", v, 8'h42);
    rd(3'd3, v);
    check("R9 lo within reload range", (v >= 8'hFC) ? 1 : 0, 1);
    repeat (10) @(negedge clk);
    rd(3'd3, v2); check("R9 lo held when stopped", v2, v);

    // R10: split high byte free-runs with run off
    for (int hi = 8'hF8; hi <= 8'hFF; hi++) begin
      p = 256 - hi;
      start(8'h02, {8'(hi), 8'h33});
      repeat (p + 4) @(negedge clk);
      count_pulses(3 * p, c);
      check("R10 hi period", c, 3);
    end
    rd(3'd3, v); check("R10 lo untouched", v, 8'h33);
    rd(3'd0, v); check("R10 hi flag", v, 8'h82);

    // R11: write overrides counting
    start(8'h01, 16'h0000);
    repeat (5) @(negedge clk);
    wr(3'd3, 8'h10);
    rd(3'd3, v); check("R11 lo write", v, 8'h10);
    wr(3'd4, 8'h20);
    rd(3'd4, v); check("R11 hi write", v, 8'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule